// File: doc/BRIEF.md
# Eight-Channel Low-Side Switch Control and Diagnostics

This block holds the digital control and status logic for eight low-side power switches. A latched serial command word decides which channels are on. The first two channels can also be switched by active-low parallel inputs, so that a PWM source can drive them without going through the serial path. Each channel has an overload latch that turns it off when protection trips.

There are two protection styles. Channels 1 to 6 shut down on an overcurrent flag. Channels 7 and 8 run through overcurrent in limit mode and shut down only on an overtemperature flag.

Every channel reports a status bit built from its commanded state and a comparator result. The comparator result says whether the output voltage sits above the diagnostic threshold. On channels 3 to 8 the status is passed straight through. On channels 1 and 2 it is first debounced by a cycle-count filter and then held in a fault latch, which is cleared while chip select is low.

An internal reset turns every channel off and clears all state. It is asserted by the system reset, by a low level on the external reset input, or by the undervoltage flag.

Top module: `lowside_ctrl`

## Requirements
- R1: Channels 1 and 2 (bit 0 and bit 1 of every vector) are enabled when their parallel input `par_n` bit is 0 or their `cmd_bits` bit is 1. They are off only when the parallel bit is 1 and the command bit is 0.
- R2: Channels 3 to 8 (bits 2 to 7) are enabled exactly when their `cmd_bits` bit is 1, apart from protection and reset.
- R3: On channels 1 to 6, an `ovc_flag` bit of 1 while the channel is commanded on drops that channel's `gate_en` bit in the same cycle. The channel then stays off after the flag goes away.
- R4: On channels 7 and 8, an `ovt_flag` bit of 1 (bit 0 is channel 7) drops `gate_en` in the same cycle and latches the channel off. The overcurrent flags have no effect on these two channels.
- R5: An overload latch is cleared at the first clock edge at which its channel is commanded off. The channel is enabled again as soon as it is commanded on.
- R6: On channels 3 to 8, `status` is combinational. A channel commanded off reports `above_thr`. A channel commanded on reports the inverse of `above_thr`. A status of 1 means OK.
- R7: On channels 1 and 2, a raw fault must hold for FILT_CYCLES consecutive clock edges before it passes the filter. The status bit goes to 0 one edge after that. A raw fault shorter than FILT_CYCLES edges changes nothing.
- R8: A fault that has passed the filter on channel 1 or 2 keeps `status` at 0 after the raw condition clears. It stays at 0 until a clock edge at which `cs_n` is low, and `status` reads 1 on the cycle after such an edge.
- R9: While `ext_rst_n` is 0 or `uv_flag` is 1, every `gate_en` bit is 0 and every channel counts as commanded off for status. All overload latches are cleared by such a reset, even if the command stays on.
- R10: After the system reset `rst`, with all commands off and `above_thr` all 1, `gate_en` reads 8'h00 and `status` reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cmd_bits | input | 8 | Latched serial command bits, bit i is channel i+1 |
| par_n | input | 2 | Active-low parallel enables for channels 1 and 2 |
| above_thr | input | 8 | Comparator result, 1 when the output is above the diagnostic threshold |
| ovc_flag | input | 6 | Overcurrent flags for channels 1 to 6 |
| ovt_flag | input | 2 | Overtemperature flags for channels 7 and 8 |
| cs_n | input | 1 | Chip-select level, low clears the channel 1 and 2 fault latches |
| ext_rst_n | input | 1 | External active-low reset |
| uv_flag | input | 1 | Undervoltage flag, high forces reset |
| gate_en | output | 8 | Gate enable per channel |
| status | output | 8 | Status per channel, 1 means OK |

## Verification
The filter's terminal count can land in the same cycle as a chip-select clear on channels 1 and 2. A protection trip can also coincide with a command change. The bench holds a raw fault for exactly one cycle less than the filter length and then for the full length. It checks that only the second run reaches the status, and that it appears exactly one edge after the count completes. It then drops chip select while the latched fault persists and expects the status to read OK on the next cycle. Trips are judged in the same cycle they occur: the enable must already be low before the next edge, and the channel must stay low until the command bit has been low across one edge.

// File: rtl/lowside_pkg.sv
package lowside_pkg;

    localparam int DEF_NUM_CH  = 8;
    localparam int DEF_NUM_PAR = 2;
    localparam int DEF_NUM_OCS = 6;

    // How a channel reacts to its protection flags
    typedef enum logic {
        TRIP_SHUTDOWN = 1'b0,   // overcurrent latches the channel off
        TRIP_THERMAL  = 1'b1    // current limit runs on, overtemperature latches off
    } trip_style_e;

    // Status meaning depends on the commanded state: off expects a high output,
    // on expects a low output.
    function automatic logic status_ok(input logic on, input logic above);
        return on ? ~above : above;
    endfunction

    function automatic trip_style_e style_of(input int idx, input int n_ocs);
        return (idx < n_ocs) ? TRIP_SHUTDOWN : TRIP_THERMAL;
    endfunction

endpackage

// File: rtl/lowside_chan.sv
module lowside_chan
    import lowside_pkg::*;
#(
    parameter trip_style_e STYLE = TRIP_SHUTDOWN
) (
    input  logic clk,
    input  logic rst_int,
    input  logic cmd_on,
    input  logic ovc,
    input  logic ovt,
    output logic gate_en
);

    logic trip;
    logic ovl_q;

    generate
        if (STYLE == TRIP_SHUTDOWN) begin : g_shutdown
            logic unused_ovt;
            assign unused_ovt = ovt;
            assign trip = ovc;
        end else begin : g_thermal
            logic unused_ovc;
            assign unused_ovc = ovc;
            assign trip = ovt;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst_int || !cmd_on) begin
            ovl_q <= 1'b0;
        end else if (trip) begin
            ovl_q <= 1'b1;
        end
    end

    // Trip acts in the same cycle; the latch keeps the channel off afterwards
    assign gate_en = cmd_on & ~rst_int & ~ovl_q & ~trip;

endmodule

// File: rtl/lowside_diag_filt.sv
module lowside_diag_filt #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_int,
    input  logic raw_ok,
    input  logic cs_n,
    output logic stat_ok
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;
    logic          fault_q;

    always_ff @(posedge clk) begin
        if (rst_int) begin
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else if (raw_ok == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            filt_q <= raw_ok;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_int || !cs_n) begin
            fault_q <= 1'b0;
        end else if (!filt_q) begin
            fault_q <= 1'b1;
        end
    end

    assign stat_ok = ~fault_q;

endmodule

// File: rtl/lowside_ctrl.sv
module lowside_ctrl
    import lowside_pkg::*;
#(
    parameter int NUM_CH      = DEF_NUM_CH,
    parameter int NUM_PAR     = DEF_NUM_PAR,
    parameter int NUM_OCS     = DEF_NUM_OCS,
    parameter int FILT_CYCLES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CH-1:0]           cmd_bits,
    input  logic [NUM_PAR-1:0]          par_n,
    input  logic [NUM_CH-1:0]           above_thr,
    input  logic [NUM_OCS-1:0]          ovc_flag,
    input  logic [NUM_CH-NUM_OCS-1:0]   ovt_flag,
    input  logic                        cs_n,
    input  logic                        ext_rst_n,
    input  logic                        uv_flag,
    output logic [NUM_CH-1:0]           gate_en,
    output logic [NUM_CH-1:0]           status
);

    logic              rst_int;
    logic [NUM_CH-1:0] cmd_on;
    logic [NUM_CH-1:0] raw_ok;

    assign rst_int = rst | ~ext_rst_n | uv_flag;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            localparam trip_style_e STY = style_of(i, NUM_OCS);
            logic ovc_i;
            logic ovt_i;

            if (i < NUM_PAR) begin : g_par
                assign cmd_on[i] = cmd_bits[i] | ~par_n[i];
            end else begin : g_ser
                assign cmd_on[i] = cmd_bits[i];
            end

            if (i < NUM_OCS) begin : g_oc
                assign ovc_i = ovc_flag[i];
                assign ovt_i = 1'b0;
            end else begin : g_ot
                assign ovc_i = 1'b0;
                assign ovt_i = ovt_flag[i-NUM_OCS];
            end

            lowside_chan #(
                .STYLE (STY)
            ) u_chan (
                .clk     (clk),
                .rst_int (rst_int),
                .cmd_on  (cmd_on[i]),
                .ovc     (ovc_i),
                .ovt     (ovt_i),
                .gate_en (gate_en[i])
            );

            assign raw_ok[i] = status_ok(cmd_on[i] & ~rst_int, above_thr[i]);

            if (i < NUM_PAR) begin : g_filt
                lowside_diag_filt #(
                    .CYCLES (FILT_CYCLES)
                ) u_filt (
                    .clk     (clk),
                    .rst_int (rst_int),
                    .raw_ok  (raw_ok[i]),
                    .cs_n    (cs_n),
                    .stat_ok (status[i])
                );
            end else begin : g_direct
                assign status[i] = raw_ok[i];
            end
        end
    endgenerate

endmodule

// File: rtl/lowside_ctrl_chk.sv
module lowside_ctrl_chk #(
    parameter int NUM_CH  = 8,
    parameter int NUM_PAR = 2,
    parameter int NUM_OCS = 6
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_CH-1:0]         cmd_bits,
    input logic [NUM_OCS-1:0]        ovc_flag,
    input logic [NUM_CH-NUM_OCS-1:0] ovt_flag,
    input logic                      cs_n,
    input logic                      ext_rst_n,
    input logic                      uv_flag,
    input logic [NUM_CH-1:0]         gate_en,
    input logic [NUM_CH-1:0]         status
);

    // R2: a serial-only channel is never on without its command bit
    assert_serial_needs_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        (gate_en[NUM_CH-1:NUM_PAR] & ~cmd_bits[NUM_CH-1:NUM_PAR]) == '0);

    // R3: an overcurrent flag and an enabled gate never coexist on channels 1..6
    assert_ovc_off_R3: assert property (@(posedge clk) disable iff (rst)
        (gate_en[NUM_OCS-1:0] & ovc_flag) == '0);

    // R4: an overtemperature flag and an enabled gate never coexist on channels 7..8
    assert_ovt_off_R4: assert property (@(posedge clk) disable iff (rst)
        (gate_en[NUM_CH-1:NUM_OCS] & ovt_flag) == '0);

    // R8: chip select low clears the latched faults of channels 1..2
    assert_cs_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> status[NUM_PAR-1:0] == '1);

    // R9: external reset or undervoltage forces all gates off
    assert_reset_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!ext_rst_n || uv_flag) |-> gate_en == '0);

endmodule

bind lowside_ctrl lowside_ctrl_chk #(
    .NUM_CH  (NUM_CH),
    .NUM_PAR (NUM_PAR),
    .NUM_OCS (NUM_OCS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_bits  (cmd_bits),
    .ovc_flag  (ovc_flag),
    .ovt_flag  (ovt_flag),
    .cs_n      (cs_n),
    .ext_rst_n (ext_rst_n),
    .uv_flag   (uv_flag),
    .gate_en   (gate_en),
    .status    (status)
);

// File: tb/lowside_ctrl_bench.sv
module lowside_ctrl_bench;

    localparam int FILT = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] cmd_bits;
    logic [1:0] par_n;
    logic [7:0] above_thr;
    logic [5:0] ovc_flag;
    logic [1:0] ovt_flag;
    logic       cs_n;
    logic       ext_rst_n;
    logic       uv_flag;
    logic [7:0] gate_en;
    logic [7:0] status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lowside_ctrl #(
        .FILT_CYCLES (FILT)
    ) u_lowside_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_bits  (cmd_bits),
        .par_n     (par_n),
        .above_thr (above_thr),
        .ovc_flag  (ovc_flag),
        .ovt_flag  (ovt_flag),
        .cs_n      (cs_n),
        .ext_rst_n (ext_rst_n),
        .uv_flag   (uv_flag),
        .gate_en   (gate_en),
        .status    (status)
    );

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] above;
        logic [1:0] par;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'h00, 2'b11},
        '{8'hFF, 8'h00, 2'b11},
        '{8'hA5, 8'h0F, 2'b11},
        '{8'h5A, 8'hF0, 2'b10},
        '{8'h00, 8'hFF, 2'b00},
        '{8'hC3, 8'h3C, 2'b01},
        '{8'h81, 8'h81, 2'b11},
        '{8'h7E, 8'hAA, 2'b11}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Reference model of the combinational part (R1, R2, R6)
    function automatic logic [7:0] model_en(input logic [7:0] c, input logic [1:0] p);
        return c | {6'b0, ~p};
    endfunction

    function automatic logic [7:0] model_st(input logic [7:0] on, input logic [7:0] a);
        return (on & ~a) | (~on & a);
    endfunction

    task automatic run_watch;
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial run_watch();

    initial begin
        rst       = 1'b1;
        cmd_bits  = 8'h00;
        par_n     = 2'b11;
        above_thr = 8'hFF;
        ovc_flag  = '0;
        ovt_flag  = '0;
        cs_n      = 1'b1;
        ext_rst_n = 1'b1;
        uv_flag   = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
        #1;
        check("R10 gate_en", gate_en, 8'h00);
        check("R10 status", status, 8'hFF);

        // Vector table: enables and direct status
        for (int v = 0; v < NVEC; v++) begin
            cmd_bits  = VECS[v].cmd;
            above_thr = VECS[v].above;
            par_n     = VECS[v].par;
            #1;
            check("R1 R2 enable table", gate_en, model_en(VECS[v].cmd, VECS[v].par));
            check("R6 status table", {status[7:2], 2'b00},
                  {model_st(model_en(VECS[v].cmd, VECS[v].par), VECS[v].above)} & 8'hFC);
            tick(1);
        end

        // Exhaustive command x comparator on every channel
        par_n = 2'b11;
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < 2; a++) begin
                cmd_bits  = {8{c[0]}};
                above_thr = {8{a[0]}};
                #1;
                check("R2 enable sweep", gate_en, {8{c[0]}});
                check("R6 status sweep", status & 8'hFC, {8{c[0] ^ a[0]}} & 8'hFC);
                tick(1);
            end
        end

        // Clean state
        cmd_bits = 8'h00; above_thr = 8'hFF; rst = 1'b1;
        tick(1);
        rst = 1'b0;

        // R1: parallel input alone turns channel 1 on; off only when both inactive
        par_n = 2'b10;
        #1;
        check("R1 par on", gate_en, 8'h01);
        par_n = 2'b11;
        #1;
        check("R1 par off", gate_en, 8'h00);
        tick(1);

        // R3 / R5: overcurrent on channel 3
        cmd_bits = 8'h04;
        tick(1);
        check("R3 pre-trip", gate_en, 8'h04);
        ovc_flag = 6'b000100;
        #1;
        check("R3 same-cycle off", gate_en, 8'h00);
        tick(1);
        ovc_flag = '0;
        #1;
        check("R3 latched off", gate_en, 8'h00);
        tick(2);
        check("R3 still latched", gate_en, 8'h00);
        cmd_bits = 8'h00;
        tick(1);
        cmd_bits = 8'h04;
        #1;
        check("R5 re-enable after off", gate_en, 8'h04);
        tick(1);

        // R4: channels 7/8 use the thermal flag
        cmd_bits = 8'hC0;
        ovc_flag = 6'b111111;
        #1;
        check("R4 ovc ignored on 7/8", gate_en, 8'hC0);
        ovc_flag = '0;
        ovt_flag = 2'b01;
        #1;
        check("R4 ovt off ch7", gate_en, 8'h80);
        tick(1);
        ovt_flag = '0;
        #1;
        check("R4 ch7 latched", gate_en, 8'h80);
        cmd_bits = 8'h00;
        tick(1);
        cmd_bits = 8'hC0;
        #1;
        check("R5 ch7 re-enable", gate_en, 8'hC0);
        tick(1);

        // R9: external reset and undervoltage
        cmd_bits  = 8'hFF;
        above_thr = 8'hFF;
        ext_rst_n = 1'b0;
        #1;
        check("R9 ext reset off", gate_en, 8'h00);
        check("R9 status as off", status & 8'hFC, 8'hFC);
        tick(1);
        ext_rst_n = 1'b1;
        uv_flag   = 1'b1;
        #1;
        check("R9 undervoltage off", gate_en, 8'h00);
        tick(1);
        uv_flag  = 1'b0;
        cmd_bits = 8'h08;
        ovc_flag = 6'b001000;
        tick(1);
        ovc_flag = '0;
        #1;
        check("R9 latch set before", gate_en, 8'h00);
        uv_flag = 1'b1;
        tick(1);
        uv_flag = 1'b0;
        #1;
        check("R9 reset clears latch", gate_en, 8'h08);

        // Clean filter state
        cmd_bits = 8'h00; above_thr = 8'hFF; par_n = 2'b11;
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        tick(1);

        // R7: raw fault one cycle short of the filter length
        above_thr = 8'hFC;
        tick(FILT - 1);
        above_thr = 8'hFF;
        tick(4);
        check("R7 short glitch filtered", status & 8'h03, 8'h03);

        // R7: raw fault for the full length, status drops one edge later
        above_thr = 8'hFC;
        tick(FILT);
        check("R7 not yet latched", status & 8'h03, 8'h03);
        tick(1);
        check("R7 fault reported", status & 8'h03, 8'h00);

        // R8: held after raw clears, cleared by chip select low
        above_thr = 8'hFF;
        tick(FILT + 3);
        check("R8 fault held", status & 8'h03, 8'h00);
        cs_n = 1'b0;
        tick(1);
        check("R8 cleared by cs", status & 8'h03, 8'h03);
        cs_n = 1'b1;
        tick(2);
        check("R8 stays clear", status & 8'h03, 8'h03);

        // R1/R7: channel 1 on via parallel input with output high (short to battery)
        par_n = 2'b10;
        tick(FILT + 1);
        check("R1 par enable", gate_en, 8'h01);
        check("R7 short to battery ch1", status & 8'h03, 8'h02);
        par_n = 2'b11;
        tick(FILT + 2);
        cs_n = 1'b0;
        tick(1);
        cs_n = 1'b1;
        check("R8 ch1 cleared", status & 8'h03, 8'h03);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule